// File: doc/BRIEF.md
# Paged Table-Lookup Reader

This block serves the table-read instructions of a small 8-bit controller whose program memory is 16 bits wide. A command names a data-memory destination and chooses the page to read from. The page is either the one the program counter currently sits in, or the top page of program memory. The low address bits come from an 8-bit lookup-pointer register, which software loads beforehand through a simple register port.

Each accepted command issues one synchronous program-memory read. The low byte of the returned word is written to the named data-memory location. The high byte is latched into a read-only upper-byte register, which only this sequence ever writes.

An operation occupies two cycles. In the fetch cycle the busy output is high and the program-memory read is presented. In the write cycle the data-memory strobe fires and the upper-byte register loads. A command offered while the block is busy is dropped. A command offered during the write cycle is accepted, so reads can follow each other every second cycle.

Top module: `tblrd_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the lookup pointer, the upper-byte register, `busy` and `dm_wr_en` all become 0.
- R2: A command accepted with `cmd_last_page`=0 presents `pm_addr` = {`pc_page`, pointer} in the following cycle, with `pm_rd_en`=1.
- R3: A command accepted with `cmd_last_page`=1 presents `pm_addr` with every page bit set to 1 (word 1F00h plus the pointer at default widths).
- R4: In the cycle after the fetch cycle, `dm_wr_en`=1, `dm_wr_addr` equals the command's destination, and `dm_wr_data` equals bits 7..0 of `pm_rd_data`.
- R5: At the end of that write cycle, `th_rd_data` loads bits 15..8 of `pm_rd_data`.
- R6: `th_rd_data` changes at no other time; pointer writes and idle cycles leave it unchanged.
- R7: `tp_wr_en`=1 loads `tp_wr_data` into the pointer, and `tp_rd_data` shows it from the next cycle on.
- R8: A command is accepted when `cmd_valid`=1 and `busy`=0. `busy` and `pm_rd_en` are then high for exactly one cycle, followed by exactly one `dm_wr_en` cycle.
- R9: A command offered while `busy`=1 is ignored. It starts no fetch, and the operation already in progress keeps its address and destination.
- R10: A pointer write in the same cycle a command is accepted does not affect that command's address; the read uses the pointer value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Table-read command request |
| cmd_last_page | input | 1 | 1 = top page of memory, 0 = current program-counter page |
| cmd_dst | input | DM_AW | Data-memory destination of the low byte |
| pc_page | input | ADDR_W-PTR_W | Page bits of the program counter |
| tp_wr_en | input | 1 | Lookup-pointer write strobe |
| tp_wr_data | input | PTR_W | Lookup-pointer write value |
| tp_rd_data | output | PTR_W | Lookup-pointer read value |
| th_rd_data | output | WORD_W/2 | Upper-byte register (read-only) |
| busy | output | 1 | Fetch cycle in progress |
| pm_rd_en | output | 1 | Program-memory read enable |
| pm_addr | output | ADDR_W | Program-memory word address |
| pm_rd_data | input | WORD_W | Program-memory word, valid the cycle after `pm_rd_en` |
| dm_wr_en | output | 1 | Data-memory write strobe |
| dm_wr_addr | output | DM_AW | Data-memory write address |
| dm_wr_data | output | WORD_W/2 | Data-memory write byte |

## Verification
The bench builds the block with its default parameters: a 13-bit word address, an 8-bit pointer, a 16-bit word and an 8-bit data-memory address. At these widths the top page at 1F00h can be reached, and a sweep covers all 32 program-counter pages, including pages 00h and 1Fh. Pointer values 00h and FFh cover both ends of each page. The stimulus includes back-to-back commands, commands dropped during the fetch cycle, and pointer writes that collide with an accepted command.

// File: rtl/tblrd_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the paged table-lookup reader.
// Assumes: a single page-select bit chooses between the current page and the top page.
package tblrd_pkg;

    typedef enum logic {
        PAGE_CURRENT = 1'b0,
        PAGE_TOP     = 1'b1
    } page_sel_e;

endpackage

// File: rtl/tblrd_ptr_reg.sv
`timescale 1ns/1ps
// Module: lookup-pointer register.
// Holds the low address bits for table reads; software writes it through a strobe.
// Assumes: synchronous active-low reset clears it to zero.
module tblrd_ptr_reg #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_data,
    output logic [PTR_W-1:0] ptr
);

    // Load the pointer on a write strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_en) begin
            ptr <= wr_data;
        end
    end

    // R7
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == $past(wr_data)));

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ptr));

endmodule

// File: rtl/tblrd_addr_gen.sv
`timescale 1ns/1ps
// Module: table-read address former.
// Concatenates page bits and the lookup pointer. Each page bit comes either from
// the program counter or is forced to one for the top page.
// Assumes: ADDR_W > PTR_W, so at least one page bit exists.
module tblrd_addr_gen
    import tblrd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PTR_W  = 8
) (
    input  page_sel_e                 page_sel,
    input  logic [ADDR_W-PTR_W-1:0]   pc_page,
    input  logic [PTR_W-1:0]          ptr,
    output logic [ADDR_W-1:0]         addr
);

    localparam int PAGE_W = ADDR_W - PTR_W;

    // Low bits: straight from the pointer.
    always_comb begin
        addr[PTR_W-1:0] = ptr;
    end

    // Page bits: one selector per bit.
    for (genvar g = 0; g < PAGE_W; g++) begin : g_page_bit
        always_comb begin
            addr[PTR_W+g] = (page_sel == PAGE_TOP) ? 1'b1 : pc_page[g];
        end
    end

endmodule

// File: rtl/tblrd_seq.sv
`timescale 1ns/1ps
// Module: two-phase table-read sequencer.
// Accepts a command when idle, holds its address for one fetch cycle, then
// raises the write phase for one cycle with the saved destination.
// Assumes: the program memory returns data one cycle after the read enable.
module tblrd_seq #(
    parameter int ADDR_W = 13,
    parameter int DM_AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DM_AW-1:0]  cmd_dst,
    output logic              fetch_act,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              write_act,
    output logic [DM_AW-1:0]  write_dst
);

    logic             accept;
    logic [DM_AW-1:0] fetch_dst;

    // Accept only when no fetch is in flight.
    always_comb begin
        accept = cmd_valid && !fetch_act;
    end

    // Fetch phase flag: set by an accepted command, lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_act <= 1'b0;
        end else begin
            fetch_act <= accept;
        end
    end

    // Capture address and destination of an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_addr <= '0;
            fetch_dst  <= '0;
        end else if (accept) begin
            fetch_addr <= cmd_addr;
            fetch_dst  <= cmd_dst;
        end
    end

    // Write phase follows the fetch phase by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_act <= 1'b0;
            write_dst <= '0;
        end else begin
            write_act <= fetch_act;
            if (fetch_act) begin
                write_dst <= fetch_dst;
            end
        end
    end

    // R8
    fetch_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_act |=> write_act);

    // R8
    write_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        write_act |-> $past(fetch_act));

    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && fetch_act) |=> !fetch_act);

    // R9
    busy_dst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_act |=> (write_dst == $past(fetch_dst)));

endmodule

// File: rtl/tblrd_high_reg.sv
`timescale 1ns/1ps
// Module: read-only upper-byte register.
// Loads the high byte of the fetched word during the write phase only.
// Assumes: load and data arrive in the same cycle.
module tblrd_high_reg #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] d,
    output logic [BYTE_W-1:0] q
);

    // Capture the upper byte on load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    // R5
    high_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R6
    high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/tblrd_top.sv
`timescale 1ns/1ps
// Module: paged table-lookup reader (top).
// Forms a table address from a page and the lookup pointer and reads program
// memory. The low byte goes to data memory; the high byte goes to a read-only register.
// Assumes: synchronous program memory with one cycle of read latency, and
// WORD_W equal to twice the data-memory byte width.
module tblrd_top
    import tblrd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PTR_W  = 8,
    parameter int WORD_W = 16,
    parameter int DM_AW  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic                    cmd_last_page,
    input  logic [DM_AW-1:0]        cmd_dst,
    input  logic [ADDR_W-PTR_W-1:0] pc_page,
    input  logic                    tp_wr_en,
    input  logic [PTR_W-1:0]        tp_wr_data,
    output logic [PTR_W-1:0]        tp_rd_data,
    output logic [WORD_W/2-1:0]     th_rd_data,
    output logic                    busy,
    output logic                    pm_rd_en,
    output logic [ADDR_W-1:0]       pm_addr,
    input  logic [WORD_W-1:0]       pm_rd_data,
    output logic                    dm_wr_en,
    output logic [DM_AW-1:0]        dm_wr_addr,
    output logic [WORD_W/2-1:0]     dm_wr_data
);

    localparam int BYTE_W = WORD_W / 2;
    localparam int PAGE_W = ADDR_W - PTR_W;

    logic [PTR_W-1:0]  ptr;
    logic [ADDR_W-1:0] cmd_addr;
    page_sel_e         page_sel;
    logic              fetch_act;
    logic              write_act;
    logic [DM_AW-1:0]  write_dst;

    // Map the command's page bit onto the page-select type.
    always_comb begin
        page_sel = page_sel_e'(cmd_last_page);
    end

    tblrd_ptr_reg #(.PTR_W(PTR_W)) ptr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tp_wr_en),
        .wr_data (tp_wr_data),
        .ptr     (ptr)
    );

    tblrd_addr_gen #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) addr_i (
        .page_sel (page_sel),
        .pc_page  (pc_page),
        .ptr      (ptr),
        .addr     (cmd_addr)
    );

    tblrd_seq #(.ADDR_W(ADDR_W), .DM_AW(DM_AW)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_addr   (cmd_addr),
        .cmd_dst    (cmd_dst),
        .fetch_act  (fetch_act),
        .fetch_addr (pm_addr),
        .write_act  (write_act),
        .write_dst  (write_dst)
    );

    tblrd_high_reg #(.BYTE_W(BYTE_W)) high_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (write_act),
        .d     (pm_rd_data[WORD_W-1:BYTE_W]),
        .q     (th_rd_data)
    );

    // Drive the external read, write and status ports from the sequencer.
    always_comb begin
        busy       = fetch_act;
        pm_rd_en   = fetch_act;
        dm_wr_en   = write_act;
        dm_wr_addr = write_dst;
        dm_wr_data = pm_rd_data[BYTE_W-1:0];
        tp_rd_data = ptr;
    end

    // R3
    top_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_last_page) |=> (pm_addr[ADDR_W-1:PTR_W] == {PAGE_W{1'b1}}));

    // R2
    cur_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !cmd_last_page) |=> (pm_addr[ADDR_W-1:PTR_W] == $past(pc_page)));

    // R10
    ptr_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> (pm_addr[PTR_W-1:0] == $past(tp_rd_data)));

    // R8
    one_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> (pm_rd_en && busy));

endmodule

// File: tb/tblrd_top_tb_top.sv
`timescale 1ns/1ps
module tblrd_top_tb_top;

    localparam int ADDR_W = 13;
    localparam int PTR_W  = 8;
    localparam int WORD_W = 16;
    localparam int DM_AW  = 8;
    localparam int PAGE_W = ADDR_W - PTR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_last_page = 1'b0;
    logic [DM_AW-1:0]  cmd_dst = '0;
    logic [PAGE_W-1:0] pc_page = '0;
    logic              tp_wr_en = 1'b0;
    logic [PTR_W-1:0]  tp_wr_data = '0;
    logic [PTR_W-1:0]  tp_rd_data;
    logic [7:0]        th_rd_data;
    logic              busy;
    logic              pm_rd_en;
    logic [ADDR_W-1:0] pm_addr;
    logic [WORD_W-1:0] pm_rd_data = '0;
    logic              dm_wr_en;
    logic [DM_AW-1:0]  dm_wr_addr;
    logic [7:0]        dm_wr_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tblrd_top dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_last_page(cmd_last_page),
        .cmd_dst(cmd_dst), .pc_page(pc_page), .tp_wr_en(tp_wr_en), .tp_wr_data(tp_wr_data),
        .tp_rd_data(tp_rd_data), .th_rd_data(th_rd_data), .busy(busy), .pm_rd_en(pm_rd_en),
        .pm_addr(pm_addr), .pm_rd_data(pm_rd_data), .dm_wr_en(dm_wr_en),
        .dm_wr_addr(dm_wr_addr), .dm_wr_data(dm_wr_data)
    );

    // Program memory contents, computed from the address.
    function automatic logic [15:0] word_of(input logic [12:0] a);
        logic [31:0] t;
        t = {19'd0, a} * 32'd40503 + 32'h1357;
        return t[15:0];
    endfunction

    // Synchronous program memory model.
    always @(posedge clk) begin
        if (pm_rd_en) pm_rd_data <= word_of(pm_addr);
    end

    // Behavioural reference state.
    int m_tp, m_th, m_busy, m_addr, m_dst, m_last, m_race;
    int m_wr, m_wr_dst, m_word, m_th_loaded, m_ign;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tp = 0; m_th = 0; m_busy = 0; m_addr = 0; m_dst = 0; m_last = 0; m_race = 0;
            m_wr = 0; m_wr_dst = 0; m_word = 0; m_th_loaded = 0; m_ign = 0;
        end else begin
            m_th_loaded = m_wr;
            if (m_wr != 0) m_th = (m_word >> 8) & 255;
            m_wr = m_busy;
            if (m_busy != 0) begin
                m_wr_dst = m_dst;
                m_word = int'(word_of(13'(m_addr)));
            end
            m_ign = (cmd_valid && m_busy != 0) ? 1 : 0;
            if (cmd_valid && m_busy == 0) begin
                m_busy = 1;
                m_last = cmd_last_page ? 1 : 0;
                m_race = tp_wr_en ? 1 : 0;
                m_addr = (cmd_last_page ? 31 : int'(pc_page)) * 256 + m_tp;
                m_dst = int'(cmd_dst);
            end else begin
                m_busy = 0;
            end
            if (tp_wr_en) m_tp = int'(tp_wr_data);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(m_ign != 0 ? "R9" : "R8", "busy", int'(busy), m_busy);
            chk("R8", "pm_rd_en", int'(pm_rd_en), m_busy);
            if (m_busy != 0)
                chk(m_race != 0 ? "R10" : (m_last != 0 ? "R3" : "R2"), "pm_addr", int'(pm_addr), m_addr);
            chk("R8", "dm_wr_en", int'(dm_wr_en), m_wr);
            if (m_wr != 0) begin
                chk("R4", "dm_wr_addr", int'(dm_wr_addr), m_wr_dst);
                chk("R4", "dm_wr_data", int'(dm_wr_data), m_word & 255);
            end
            chk("R7", "tp_rd_data", int'(tp_rd_data), m_tp);
            chk(m_th_loaded != 0 ? "R5" : "R6", "th_rd_data", int'(th_rd_data), m_th);
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // One cycle of stimulus, applied just after a falling edge.
    task automatic cyc(input bit cv, input bit last, input int dst, input int pg,
                       input bit tw, input int td);
        cmd_valid = cv; cmd_last_page = last; cmd_dst = DM_AW'(dst);
        pc_page = PAGE_W'(pg); tp_wr_en = tw; tp_wr_data = PTR_W'(td);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        // R1: reset state
        chk("R1", "tp_rd_data reset", int'(tp_rd_data), 0);
        chk("R1", "th_rd_data reset", int'(th_rd_data), 0);
        chk("R1", "busy reset", int'(busy), 0);
        chk("R1", "dm_wr_en reset", int'(dm_wr_en), 0);
        rst_n = 1'b1;
        idle(1);
        // R7: pointer load
        cyc(0, 0, 0, 0, 1, 8'h34);
        idle(2);
        // R2: current page read
        cyc(1, 0, 8'h10, 5'h0A, 0, 0);
        idle(3);
        // R3: top page read
        cyc(1, 1, 8'h20, 5'h03, 0, 0);
        idle(3);
        // R2/R3 page and pointer extremes
        cyc(0, 0, 0, 0, 1, 8'hFF); idle(1);
        cyc(1, 0, 8'h31, 5'h1F, 0, 0); idle(2);
        cyc(0, 0, 0, 0, 1, 8'h00); idle(1);
        cyc(1, 0, 8'h32, 5'h00, 0, 0); idle(2);
        cyc(1, 1, 8'h33, 5'h00, 0, 0); idle(2);
        // R9: command while busy is dropped; R8: next accepted in write phase
        cyc(0, 0, 0, 0, 1, 8'h5C); idle(1);
        cyc(1, 0, 8'h40, 5'h07, 0, 0);
        cyc(1, 1, 8'h41, 5'h12, 0, 0);
        cyc(1, 1, 8'h42, 5'h02, 0, 0);
        idle(3);
        // R10: pointer write alongside accepted command
        cyc(1, 0, 8'h50, 5'h04, 1, 8'h99);
        idle(3);
        // R7/R6: pointer write during busy, th unchanged by it
        cyc(1, 1, 8'h51, 5'h00, 0, 0);
        cyc(0, 0, 0, 0, 1, 8'hA1);
        idle(4);
        cyc(0, 0, 0, 0, 1, 8'h07);
        idle(3);
        // Sweep all pages, alternating page mode and pointer values
        for (int p = 0; p < 32; p++) begin
            cyc(0, 0, 0, 0, 1, (p * 37 + 11) & 255);
            cyc(1, p[0], (p * 5) & 255, p, 0, 0);
            cyc(1, !p[0], 8'hEE, p ^ 5'h15, 0, 0);
            idle(p % 3);
        end
        idle(4);
        finish_run();
    end

endmodule